// File: doc/BRIEF.md
# Line-Serial Address Pointer Controller

This block produces the running serial address for one port of a memory that is organised as lines. The address is a pair: X is the position within a line, and Y is the line number. Each accepted access strobe advances X. When a line is finished, X wraps to zero and Y steps forward. After the last line, Y also wraps to zero. The block keeps a preset address register that is separate from the running counter. Set and reset cycles can load, clear or restore one of them or both.

A chip places one instance on the write side and one on the read side, and each has its own control pins. A reset cycle on one side therefore never disturbs accesses on the other side. On a write-side instance the two sub-port enable pins are tied low.

The access strobe is a valid/ready pair. An access counts only in a cycle where `acc_valid` and `acc_ready` are both high. While `acc_ready` is low the pointer holds its value. The requester may keep `acc_valid` raised and wait, or it may drop it. No access is ever queued. `acc_ready` is low in any cycle where a set or reset cycle is being requested. It then stays low for `ENA_DLY` cycles after that cycle is accepted.

Top module: `fmem_addr_ptr`

## Requirements
- R1: After reset the pointer is (0,0), the preset register holds (0,0), `acc_ready` is high and `mode_err` is low.
- R2: Each accepted access raises X by one. When X is at `LINE_LEN-1` it returns to 0 and Y rises by one. When Y is also at `LINE_CNT-1`, Y returns to 0. The new pointer is visible in the cycle after the access.
- R3: Mode code 4 (load) writes `set_x`/`set_y` into the preset register and into the pointer, both visible in the next cycle.
- R4: Mode code 0 (counter clear) forces the pointer to (0,0) and leaves the preset register unchanged.
- R5: Mode code 1 (register clear) forces both the preset register and the pointer to (0,0). It is accepted only when `sub_en_a` and `sub_en_b` are both 0.
- R6: Mode code 2 (line clear) forces Y to 0 and leaves X unchanged.
- R7: Mode code 3 (jump) copies the preset register into the pointer.
- R8: `acc_ready` is low in every cycle where `cyc_valid` is high. It also stays low for exactly `ENA_DLY` cycles after an accepted cycle. While it is low, `acc_valid` has no effect on the pointer.
- R9: The following are prohibited requests: codes 5 to 7, a register clear with either sub-port enable high, and a load whose X is at least `LINE_LEN` or whose Y is at least `LINE_CNT`. A prohibited request raises `mode_err` for one cycle. It leaves the register, the pointer and the enable delay untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | Requests a set/reset cycle this clock |
| cyc_mode | input | 3 | Cycle code: 0 counter clear, 1 register clear, 2 line clear, 3 jump, 4 load |
| sub_en_a | input | 1 | First sub-port enable (must be 0 for register clear) |
| sub_en_b | input | 1 | Second sub-port enable (must be 0 for register clear) |
| set_x | input | XW | X address supplied for a load |
| set_y | input | YW | Y address supplied for a load |
| acc_valid | input | 1 | Access strobe request |
| acc_ready | output | 1 | Access may be taken this clock |
| ptr_x | output | XW | Current position within the line |
| ptr_y | output | YW | Current line |
| mode_err | output | 1 | One-cycle flag: the previous request was prohibited |

## Verification
The assertions assume that `cyc_mode`, `set_x` and `set_y` are steady whenever `cyc_valid` is sampled. They also assume that nothing but the clock-edge handshake is used to count accesses. The stepping and wrap checks expect the counter's control inputs to be decoded as mutually exclusive, and the top-level decode guarantees this. The bench changes inputs only one time unit after each rising edge. It requests every legal code and every prohibited code, and every sub-port enable pair. It loads and jumps to every address of a small configuration. It holds `acc_valid` high through every blocked window, so that the stall rule is exercised on each one.

// File: rtl/fap_pkg.sv
package fap_pkg;
  typedef enum logic [2:0] {
    CYC_CNT_CLR = 3'd0,
    CYC_REG_CLR = 3'd1,
    CYC_Y_CLR   = 3'd2,
    CYC_JUMP    = 3'd3,
    CYC_LOAD    = 3'd4
  } cyc_mode_e;
endpackage

// File: rtl/fap_preset_reg.sv
module fap_preset_reg #(
  parameter int XW = 3,
  parameter int YW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [XW-1:0] d_x,
  input  logic [YW-1:0] d_y,
  output logic [XW-1:0] q_x,
  output logic [YW-1:0] q_y
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      q_x <= '0;
      q_y <= '0;
    end else if (ld) begin
      q_x <= d_x;
      q_y <= d_y;
    end
  end

  // R4: the preset survives every cycle that neither clears nor loads it
  a_r4_preset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld) |=> $stable({q_x, q_y}));

  // R5: a clear leaves the preset at zero
  a_r5_preset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q_x == '0 && q_y == '0));
endmodule

// File: rtl/fap_xy_counter.sv
module fap_xy_counter #(
  parameter int LINE_LEN = 8,
  parameter int LINE_CNT = 4,
  parameter int XW = 3,
  parameter int YW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [XW-1:0] ld_x,
  input  logic [YW-1:0] ld_y,
  input  logic          zero_all,
  input  logic          zero_y,
  input  logic          adv,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y
);
  localparam logic [XW-1:0] X_LAST = XW'(LINE_LEN - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(LINE_CNT - 1);

  logic step_only;
  assign step_only = adv && !load && !zero_all && !zero_y;

  always_ff @(posedge clk) begin
    if (!rst_n || zero_all) begin
      x <= '0;
      y <= '0;
    end else if (load) begin
      x <= ld_x;
      y <= ld_y;
    end else if (zero_y) begin
      y <= '0;
    end else if (adv) begin
      if (x == X_LAST) begin
        x <= '0;
        y <= (y == Y_LAST) ? '0 : y + 1'b1;
      end else begin
        x <= x + 1'b1;
      end
    end
  end

  // R2: stepping inside a line
  a_r2_x_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_only && x != X_LAST) |=> (x == $past(x) + 1'b1 && y == $past(y)));

  // R2: end of line moves to the next line
  a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_only && x == X_LAST && y != Y_LAST) |=> (x == '0 && y == $past(y) + 1'b1));

  // R2: end of field returns to the origin
  a_r2_field_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_only && x == X_LAST && y == Y_LAST) |=> (x == '0 && y == '0));

  // R6: a line clear keeps X
  a_r6_keep_x: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_y && !zero_all && !load) |=> (y == '0 && x == $past(x)));
endmodule

// File: rtl/fap_access_gate.sv
module fap_access_gate #(
  parameter int ENA_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic restart,
  output logic ready
);
  localparam int CW = $clog2(ENA_DLY + 1);
  localparam logic [CW-1:0] DLY_INIT = CW'(ENA_DLY);

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (restart) begin
      wait_cnt <= DLY_INIT;
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end

  assign ready = (wait_cnt == '0) && !busy;

  // R8: an accepted cycle always closes the access window next clock
  a_r8_closed_after: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !ready);

  // R8: the window never reopens while a request is present
  a_r8_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready);
endmodule

// File: rtl/fmem_addr_ptr.sv
module fmem_addr_ptr
  import fap_pkg::*;
#(
  parameter int LINE_LEN = 8,
  parameter int LINE_CNT = 4,
  parameter int ENA_DLY  = 3,
  localparam int XW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1,
  localparam int YW = (LINE_CNT > 1) ? $clog2(LINE_CNT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_valid,
  input  logic [2:0]    cyc_mode,
  input  logic          sub_en_a,
  input  logic          sub_en_b,
  input  logic [XW-1:0] set_x,
  input  logic [YW-1:0] set_y,
  input  logic          acc_valid,
  output logic          acc_ready,
  output logic [XW-1:0] ptr_x,
  output logic [YW-1:0] ptr_y,
  output logic          mode_err
);
  logic is_cnt, is_reg, is_y, is_jump, is_load, bad_req, cyc_ok;
  logic [XW-1:0] pre_x;
  logic [YW-1:0] pre_y;

  always_comb begin
    is_cnt  = 1'b0;
    is_reg  = 1'b0;
    is_y    = 1'b0;
    is_jump = 1'b0;
    is_load = 1'b0;
    bad_req = 1'b0;
    if (cyc_valid) begin
      case (cyc_mode)
        CYC_CNT_CLR: is_cnt = 1'b1;
        CYC_REG_CLR: if (sub_en_a || sub_en_b) bad_req = 1'b1; else is_reg = 1'b1;
        CYC_Y_CLR:   is_y = 1'b1;
        CYC_JUMP:    is_jump = 1'b1;
        CYC_LOAD:    if (int'(set_x) >= LINE_LEN || int'(set_y) >= LINE_CNT) bad_req = 1'b1;
                     else is_load = 1'b1;
        default:     bad_req = 1'b1;
      endcase
    end
  end

  assign cyc_ok = cyc_valid && !bad_req;

  fap_preset_reg #(.XW(XW), .YW(YW)) u_preset (
    .clk(clk), .rst_n(rst_n), .clr(is_reg), .ld(is_load),
    .d_x(set_x), .d_y(set_y), .q_x(pre_x), .q_y(pre_y)
  );

  fap_xy_counter #(.LINE_LEN(LINE_LEN), .LINE_CNT(LINE_CNT), .XW(XW), .YW(YW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(is_load || is_jump),
    .ld_x(is_load ? set_x : pre_x),
    .ld_y(is_load ? set_y : pre_y),
    .zero_all(is_cnt || is_reg),
    .zero_y(is_y),
    .adv(acc_valid && acc_ready),
    .x(ptr_x), .y(ptr_y)
  );

  fap_access_gate #(.ENA_DLY(ENA_DLY)) u_gate (
    .clk(clk), .rst_n(rst_n), .busy(cyc_valid), .restart(cyc_ok), .ready(acc_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mode_err <= 1'b0;
    else        mode_err <= cyc_valid && bad_req;
  end

  // R1: the pointer never leaves the field
  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ptr_x) < LINE_LEN && int'(ptr_y) < LINE_CNT));

  // R8: a stalled or absent access leaves the pointer alone
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_valid && !(acc_valid && acc_ready)) |=> $stable({ptr_x, ptr_y}));

  // R9: a prohibited request moves nothing and flags once
  a_r9_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && bad_req) |=> ($stable({ptr_x, ptr_y}) && mode_err));

  // R9: the flag is only raised by a prohibited request
  a_r9_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_valid && bad_req) |=> !mode_err);

  // R3: a load shows the supplied address next clock
  a_r3_load_seen: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> (ptr_x == $past(set_x) && ptr_y == $past(set_y)));

  // R7: a jump shows the stored preset next clock
  a_r7_jump_seen: assert property (@(posedge clk) disable iff (!rst_n)
    is_jump |=> (ptr_x == $past(pre_x) && ptr_y == $past(pre_y)));
endmodule

// File: tb/fmem_addr_ptr_bench.sv
module fmem_addr_ptr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LL = 5;
  localparam int LC = 3;
  localparam int ED = 2;
  localparam int XW = $clog2(LL);
  localparam int YW = $clog2(LC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_valid = 1'b0;
  logic [2:0] cyc_mode = '0;
  logic sub_en_a = 1'b0, sub_en_b = 1'b0;
  logic [XW-1:0] set_x = '0;
  logic [YW-1:0] set_y = '0;
  logic acc_valid = 1'b0;
  logic acc_ready;
  logic [XW-1:0] ptr_x;
  logic [YW-1:0] ptr_y;
  logic mode_err;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int m_x = 0, m_y = 0, r_x = 0, r_y = 0, m_dly = 0;
  bit m_err = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fmem_addr_ptr #(.LINE_LEN(LL), .LINE_CNT(LC), .ENA_DLY(ED)) u_fmem_addr_ptr (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_mode(cyc_mode),
    .sub_en_a(sub_en_a), .sub_en_b(sub_en_b), .set_x(set_x), .set_y(set_y),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .ptr_x(ptr_x), .ptr_y(ptr_y),
    .mode_err(mode_err)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit cv, input int md, input bit sa, input bit sb,
                      input int sx, input int sy, input bit av, input string tag);
    bit exp_rdy;
    bit isbad;
    cyc_valid = cv; cyc_mode = 3'(md); sub_en_a = sa; sub_en_b = sb;
    set_x = XW'(sx); set_y = YW'(sy); acc_valid = av;
    #1;
    exp_rdy = !cv && (m_dly == 0);
    check(acc_ready == exp_rdy, "R8", "acc_ready", int'(acc_ready), int'(exp_rdy));
    isbad = 1'b0;
    if (cv) begin
      if (md > 4) isbad = 1'b1;
      if (md == 1 && (sa || sb)) isbad = 1'b1;
      if (md == 4 && (sx >= LL || sy >= LC)) isbad = 1'b1;
    end
    @(posedge clk); #1;
    if (cv && !isbad) begin
      m_dly = ED;
      case (md)
        0: begin m_x = 0; m_y = 0; end
        1: begin m_x = 0; m_y = 0; r_x = 0; r_y = 0; end
        2: m_y = 0;
        3: begin m_x = r_x; m_y = r_y; end
        default: begin m_x = sx; m_y = sy; r_x = sx; r_y = sy; end
      endcase
    end else begin
      if (m_dly > 0) m_dly--;
      if (av && exp_rdy) begin
        if (m_x == LL - 1) begin m_x = 0; m_y = (m_y == LC - 1) ? 0 : m_y + 1; end
        else m_x++;
      end
    end
    m_err = cv && isbad;
    check(int'(ptr_x) == m_x, tag, "ptr_x", int'(ptr_x), m_x);
    check(int'(ptr_y) == m_y, tag, "ptr_y", int'(ptr_y), m_y);
    check(mode_err == m_err, tag, "mode_err", int'(mode_err), int'(m_err));
  endtask

  task automatic acc(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: reset state
    check(ptr_x == '0 && ptr_y == '0, "R1", "ptr", int'({ptr_y, ptr_x}), 0);
    check(acc_ready == 1'b1, "R1", "acc_ready", int'(acc_ready), 1);
    check(mode_err == 1'b0, "R1", "mode_err", int'(mode_err), 0);
    @(posedge clk); #1;
    // R2: two full passes across the field plus wraps, with idle gaps
    acc(LL * LC * 2 + 2, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R2");
    acc(3, "R2");
    // R3, R7, R8: load every address, wait out the window, then jump back
    for (int y = 0; y < LC; y++) begin
      for (int x = 0; x < LL; x++) begin
        step(1, 4, 0, 0, x, y, 1, "R3");
        acc(ED + 2, "R8");
        step(1, 3, 0, 0, 0, 0, 0, "R7");
        acc(1, "R7");
      end
    end
    // R4: counter clear keeps the preset
    step(1, 4, 0, 0, 3, 1, 0, "R3");
    acc(ED + 3, "R4");
    step(1, 0, 0, 0, 0, 0, 1, "R4");
    acc(ED + 2, "R4");
    step(1, 3, 0, 0, 0, 0, 0, "R4");
    // R6: line clear keeps X
    acc(ED + 4, "R6");
    step(1, 2, 0, 0, 0, 0, 0, "R6");
    acc(ED + 1, "R6");
    // R5, R9: register clear under every sub-port enable pair
    for (int k = 3; k >= 0; k--) begin
      step(1, 4, 0, 0, 4, 2, 0, "R5");
      acc(ED + 2, "R5");
      step(1, 1, k[1], k[0], 0, 0, 1, (k == 0) ? "R5" : "R9");
      acc(2, "R9");
      step(1, 3, 0, 0, 0, 0, 0, "R5");
      acc(ED + 1, "R5");
    end
    // R9: unused codes and out-of-range loads
    for (int c = 5; c < 8; c++) begin
      step(1, c, 0, 0, 1, 1, 1, "R9");
      acc(1, "R9");
    end
    step(1, 4, 0, 0, LL, 0, 0, "R9");
    step(1, 4, 0, 0, 0, LC, 0, "R9");
    step(1, 4, 0, 0, 7, 3, 0, "R9");
    acc(ED + 1, "R9");
    step(1, 3, 0, 0, 0, 0, 0, "R9");
    acc(2, "R9");
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule